// File: doc/BRIEF.md
# Looping Pattern Segment Sequencer

This block steers a pattern word generator through a short program of segment slots. Each slot points at a run of 32-bit words in pattern memory by its first word address and its length in words, and says how that run is repeated: forever, a programmed number of times, or once. On every clock of an active program the block presents one read address with a valid strobe. It wraps the address at the end of the segment, counts passes, steps to the next slot and raises a done flag after the final slot.

Sixteen programs of up to four slots each are held in a slot table that is written one slot at a time. A single request port starts a program or switches to another one. The switch happens on the next clock when immediate switching is asked for. Otherwise it waits for the end of the segment pass that is under way. When the word source is a pseudo-random generator, a switch is always immediate.

Top module: `segloop_sequencer`

## Requirements
- R1: After a synchronous reset `rd_valid` and `done` are 0 and no program runs.
- R2: A clock with `cfg_we` high stores the base word address, the length in 32-bit words (16 to 2048, 0 treated as 1), the mode, the repeat count and the last flag into slot `cfg_slot` of program `cfg_prog`. A later run of that program uses the stored values.
- R3: A request accepted while idle starts program `req_prog`. From the next clock edge `rd_valid` is 1, `act_slot` is 0 and `rd_addr` equals that slot's base address.
- R4: While running, `rd_addr` advances by one word per clock, modulo 2^15. After the last word of the segment it returns to the base address or moves to the next segment.
- R5: Mode 0 (forever) replays its segment without end. The program leaves the slot only through a switch request.
- R6: Mode 1 (counted) plays its segment N times, where N is the 16-bit repeat count and a count of 0 counts as 1, and then advances to the next slot.
- R7: Mode 2 (play once) and mode 3 play the segment a single time and then advance to the next slot.
- R8: When the final slot ends, `done` goes to 1 and `rd_valid` to 0 on the next clock. The final slot is the slot with its last flag set, or slot 3. Both hold until a request is accepted, which clears `done`.
- R9: A request with `req_now` = 1 while running takes effect on the next clock edge at slot 0, word 0 of the new program, and discards any waiting deferred request.
- R10: A request with `req_now` = 0 while running lets the current segment pass finish. The new program then begins in place of the loop or advance. A newer deferred request replaces a waiting one.
- R11: While `src_prbs` is 1, every request is treated as immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot table write strobe |
| cfg_prog | input | 4 | Program index to write |
| cfg_slot | input | 2 | Slot index to write |
| cfg_base | input | 15 | First word address of the segment |
| cfg_words | input | 12 | Segment length in 32-bit words |
| cfg_mode | input | 2 | 0 forever, 1 counted, 2 or 3 once |
| cfg_reps | input | 16 | Repeat count for counted mode |
| cfg_last | input | 1 | Slot ends its program |
| req | input | 1 | Start or switch request |
| req_prog | input | 4 | Program to start |
| req_now | input | 1 | 1 = immediate switch, 0 = at segment end |
| src_prbs | input | 1 | Word source is pseudo-random; forces immediate switching |
| rd_addr | output | 15 | Pattern memory word address |
| rd_valid | output | 1 | Address is valid this clock |
| done | output | 1 | Program finished |
| act_prog | output | 4 | Program currently or last run |
| act_slot | output | 2 | Slot currently or last run |

## Verification
Directed programs cover four cases: a counted slot followed by a single pass, a forever slot, a four-slot chain whose base address crosses the top of memory, and a zero repeat count. The first tells pass counting apart from slot advance. The second separates deferred from immediate switching. The crossing chain shows address wrap against slot-3 termination, and the zero count shows the count-of-one rule. Requests that are deferred, immediate, and forced immediate by the pseudo-random source are then mixed with randomly built programs. A cycle-accurate reference model follows them, so the timing of segment ends, replaced deferred requests and requests that land on the last word is checked on every clock.

// File: rtl/seqr_pkg.sv
`timescale 1ns/1ps
package seqr_pkg;
    localparam int NUM_PROGS = 16;
    localparam int NUM_SLOTS = 4;
    localparam int ADDR_W    = 15;
    localparam int MAX_WORDS = 2048;
    localparam int CNT_W     = 16;
    localparam int LEN_W     = $clog2(MAX_WORDS + 1);
    localparam int PROG_W    = $clog2(NUM_PROGS);
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int ENTRIES   = NUM_PROGS * NUM_SLOTS;
    localparam int IDX_W     = $clog2(ENTRIES);

    typedef enum logic [1:0] {
        MODE_FOREVER = 2'd0,
        MODE_COUNTED = 2'd1,
        MODE_ONCE    = 2'd2,
        MODE_ONCE_B  = 2'd3
    } loop_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  words;
        loop_mode_e        mode;
        logic [CNT_W-1:0]  reps;
        logic              last;
    } slot_cfg_t;

    function automatic logic [LEN_W-1:0] eff_words(input logic [LEN_W-1:0] w);
        return (w == '0) ? LEN_W'(1) : w;
    endfunction

    function automatic logic [CNT_W-1:0] eff_reps(input logic [CNT_W-1:0] r);
        return (r == '0) ? CNT_W'(1) : r;
    endfunction

    function automatic logic is_final(input slot_cfg_t c, input logic [SLOT_W-1:0] s);
        return c.last || (s == SLOT_W'(NUM_SLOTS - 1));
    endfunction
endpackage

// File: rtl/seqr_slot_table.sv
`timescale 1ns/1ps
module seqr_slot_table
    import seqr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PROG_W-1:0] wr_prog,
    input  logic [SLOT_W-1:0] wr_slot,
    input  slot_cfg_t         wr_data,
    input  logic [PROG_W-1:0] rd_prog,
    input  logic [SLOT_W-1:0] rd_slot,
    output slot_cfg_t         rd_data
);
    slot_cfg_t         tbl [ENTRIES];
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    assign wr_idx  = {wr_prog, wr_slot};
    assign rd_idx  = {rd_prog, rd_slot};
    assign rd_data = tbl[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) tbl[e] <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_data;
        end
    end

    // R2: a written entry holds the written value one clock later
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> tbl[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/seqr_switch_ctl.sv
`timescale 1ns/1ps
module seqr_switch_ctl
    import seqr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [PROG_W-1:0] req_prog,
    input  logic              req_now,
    input  logic              src_prbs,
    input  logic              running,
    input  logic              seg_end,
    output logic              take_now,
    output logic              take_end,
    output logic [PROG_W-1:0] new_prog
);
    logic              pend_q;
    logic [PROG_W-1:0] pend_prog_q;
    logic              defer;

    assign take_now = req && (req_now || src_prbs || !running);
    assign defer    = req && !take_now;
    assign take_end = running && seg_end && !take_now && (defer || pend_q);
    assign new_prog = req ? req_prog : pend_prog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            pend_prog_q <= '0;
        end else if (take_now || take_end) begin
            pend_q      <= 1'b0;
        end else if (defer) begin
            pend_q      <= 1'b1;
            pend_prog_q <= req_prog;
        end
    end

    // R9: an immediate switch leaves no deferred request waiting
    a_r9_imm_clears_pending: assert property (@(posedge clk) disable iff (rst)
        take_now |=> !pend_q);
    // R11: with a pseudo-random source nothing is ever deferred
    a_r11_prbs_never_defers: assert property (@(posedge clk) disable iff (rst)
        (req && src_prbs) |=> !pend_q);
    // R10: a deferred request is held until a segment end takes it
    a_r10_defer_held: assert property (@(posedge clk) disable iff (rst)
        (defer && !take_end) |=> pend_q && pend_prog_q == $past(req_prog));
endmodule

// File: rtl/segloop_sequencer.sv
`timescale 1ns/1ps
module segloop_sequencer
    import seqr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [PROG_W-1:0] cfg_prog,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_words,
    input  logic [1:0]        cfg_mode,
    input  logic [CNT_W-1:0]  cfg_reps,
    input  logic              cfg_last,
    input  logic              req,
    input  logic [PROG_W-1:0] req_prog,
    input  logic              req_now,
    input  logic              src_prbs,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic              done,
    output logic [PROG_W-1:0] act_prog,
    output logic [SLOT_W-1:0] act_slot
);
    logic              running_q, done_q;
    logic [PROG_W-1:0] prog_q;
    logic [SLOT_W-1:0] slot_q;
    logic [LEN_W-1:0]  offs_q;
    logic [CNT_W-1:0]  pass_q;
    slot_cfg_t         wr_cfg, cur;
    logic              seg_end, take_now, take_end, reps_met;
    logic [PROG_W-1:0] new_prog;

    assign wr_cfg = '{base: cfg_base, words: cfg_words, mode: loop_mode_e'(cfg_mode),
                      reps: cfg_reps, last: cfg_last};

    seqr_slot_table u_table (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_prog(cfg_prog), .wr_slot(cfg_slot), .wr_data(wr_cfg),
        .rd_prog(prog_q), .rd_slot(slot_q), .rd_data(cur)
    );

    assign seg_end  = offs_q == (eff_words(cur.words) - LEN_W'(1));
    assign reps_met = ({1'b0, pass_q} + (CNT_W+1)'(1)) >= {1'b0, eff_reps(cur.reps)};

    seqr_switch_ctl u_switch (
        .clk(clk), .rst(rst),
        .req(req), .req_prog(req_prog), .req_now(req_now), .src_prbs(src_prbs),
        .running(running_q), .seg_end(seg_end),
        .take_now(take_now), .take_end(take_end), .new_prog(new_prog)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            done_q    <= 1'b0;
            prog_q    <= '0;
            slot_q    <= '0;
            offs_q    <= '0;
            pass_q    <= '0;
        end else if (take_now || take_end) begin
            running_q <= 1'b1;
            done_q    <= 1'b0;
            prog_q    <= new_prog;
            slot_q    <= '0;
            offs_q    <= '0;
            pass_q    <= '0;
        end else if (running_q) begin
            if (!seg_end) begin
                offs_q <= offs_q + LEN_W'(1);
            end else if (cur.mode == MODE_FOREVER ||
                         (cur.mode == MODE_COUNTED && !reps_met)) begin
                offs_q <= '0;
                if (cur.mode == MODE_COUNTED) pass_q <= pass_q + CNT_W'(1);
            end else begin
                offs_q <= '0;
                pass_q <= '0;
                if (is_final(cur, slot_q)) begin
                    running_q <= 1'b0;
                    done_q    <= 1'b1;
                end else begin
                    slot_q <= slot_q + SLOT_W'(1);
                end
            end
        end
    end

    assign rd_valid = running_q;
    assign rd_addr  = cur.base + ADDR_W'(offs_q);
    assign done     = done_q;
    assign act_prog = prog_q;
    assign act_slot = slot_q;

    // R8: a finished program presents no valid address
    a_r8_done_no_valid: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !running_q);
    // R8: done only rises out of a running program
    a_r8_done_from_run: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(running_q));
    // R3: an accepted start lands on slot 0, word 0
    a_r3_start_origin: assert property (@(posedge clk) disable iff (rst)
        take_now |=> running_q && offs_q == '0 && slot_q == '0);
    // R4: inside a segment the word offset steps by one
    a_r4_word_step: assert property (@(posedge clk) disable iff (rst)
        (running_q && !seg_end && !take_now) |=> offs_q == $past(offs_q) + LEN_W'(1));
    // R5: a forever slot without a switch stays in place and restarts its segment
    a_r5_forever_stays: assert property (@(posedge clk) disable iff (rst)
        (running_q && seg_end && !take_now && !take_end && cur.mode == MODE_FOREVER)
        |=> running_q && offs_q == '0 && slot_q == $past(slot_q));
endmodule

// File: tb/test_segloop_sequencer.sv
`timescale 1ns/1ps
module test_segloop_sequencer;
    import seqr_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 0, cfg_last = 0, req = 0, req_now = 0, src_prbs = 0;
    logic [PROG_W-1:0] cfg_prog = '0, req_prog = '0, act_prog;
    logic [SLOT_W-1:0] cfg_slot = '0, act_slot;
    logic [ADDR_W-1:0] cfg_base = '0, rd_addr;
    logic [LEN_W-1:0]  cfg_words = '0;
    logic [1:0]        cfg_mode = '0;
    logic [CNT_W-1:0]  cfg_reps = '0;
    logic rd_valid, done;

    always #2 clk = ~clk;

    segloop_sequencer i_segloop_sequencer (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_prog(cfg_prog), .cfg_slot(cfg_slot),
        .cfg_base(cfg_base), .cfg_words(cfg_words), .cfg_mode(cfg_mode), .cfg_reps(cfg_reps),
        .cfg_last(cfg_last), .req(req), .req_prog(req_prog), .req_now(req_now),
        .src_prbs(src_prbs), .rd_addr(rd_addr), .rd_valid(rd_valid), .done(done),
        .act_prog(act_prog), .act_slot(act_slot)
    );

    int tests = 0, fails = 0;
    bit finished = 0;

    // shadow of the slot table
    int t_base [16][4];
    int t_words[16][4];
    int t_mode [16][4];
    int t_reps [16][4];
    bit t_last [16][4];

    // reference model state
    bit m_run, m_done, m_pend;
    int m_prog, m_slot, m_off, m_left, m_pprog;

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int wlen(int p, int s);
        return (t_words[p][s] == 0) ? 1 : t_words[p][s];
    endfunction

    function automatic int exp_addr();
        return (t_base[m_prog][m_slot] + m_off) % 32768;
    endfunction

    task automatic m_enter(int p);
        m_run = 1; m_done = 0; m_prog = p; m_slot = 0; m_off = 0;
        m_left = (t_reps[p][0] == 0) ? 1 : t_reps[p][0];
    endtask

    task automatic m_advance();
        m_off = 0;
        if (t_last[m_prog][m_slot] || m_slot == 3) begin
            m_run = 0; m_done = 1;
        end else begin
            m_slot++;
            m_left = (t_reps[m_prog][m_slot] == 0) ? 1 : t_reps[m_prog][m_slot];
        end
    endtask

    task automatic m_step(bit r, int rp, bit now, bit prbs);
        bit at_end;
        if (r && (now || prbs || !m_run)) begin
            m_enter(rp); m_pend = 0; return;
        end
        if (!m_run) return;
        at_end = (m_off == wlen(m_prog, m_slot) - 1);
        if (r) begin
            if (at_end) begin m_enter(rp); m_pend = 0; end
            else begin m_pend = 1; m_pprog = rp; m_off++; end
            return;
        end
        if (!at_end) begin m_off++; return; end
        if (m_pend) begin m_enter(m_pprog); m_pend = 0; return; end
        case (t_mode[m_prog][m_slot])
            0: m_off = 0;
            1: if (m_left > 1) begin m_left--; m_off = 0; end else m_advance();
            default: m_advance();
        endcase
    endtask

    task automatic compare(string tag);
        check({tag, " valid"}, rd_valid, m_run);
        check({tag, " done"}, done, m_done);
        check({tag, " prog"}, act_prog, m_prog);
        if (m_run) begin
            check({tag, " slot"}, act_slot, m_slot);
            check({tag, " addr"}, rd_addr, exp_addr());
        end
    endtask

    task automatic tick(bit r, int rp, bit now, bit prbs, string tag);
        req = r; req_prog = PROG_W'(rp); req_now = now; src_prbs = prbs;
        m_step(r, rp, now, prbs);
        @(posedge clk); @(negedge clk);
        req = 0; req_now = 0; src_prbs = 0;
        compare(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, tag);
    endtask

    task automatic wr_slot(int p, int s, int base, int words, int mode, int reps, bit last);
        cfg_we = 1; cfg_prog = PROG_W'(p); cfg_slot = SLOT_W'(s);
        cfg_base = ADDR_W'(base); cfg_words = LEN_W'(words); cfg_mode = 2'(mode);
        cfg_reps = CNT_W'(reps); cfg_last = last;
        t_base[p][s] = base; t_words[p][s] = words; t_mode[p][s] = mode;
        t_reps[p][s] = reps; t_last[p][s] = last;
        @(posedge clk); @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: all requirements actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C1A));
        for (int p = 0; p < 16; p++)
            for (int s = 0; s < 4; s++) begin
                t_base[p][s] = 0; t_words[p][s] = 0; t_mode[p][s] = 0;
                t_reps[p][s] = 0; t_last[p][s] = 0;
            end
        m_run = 0; m_done = 0; m_pend = 0; m_prog = 0; m_slot = 0;
        m_off = 0; m_left = 1; m_pprog = 0;

        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 reset valid", rd_valid, 0);
        check("R1 reset done", done, 0);

        // R2: directed programs
        wr_slot(0, 0, 100, 16, 1, 3, 0);
        wr_slot(0, 1, 500, 20, 2, 0, 1);
        wr_slot(1, 0, 1000, 16, 0, 0, 1);
        wr_slot(2, 0, 32760, 16, 2, 0, 0);
        wr_slot(2, 1, 200, 16, 3, 0, 0);
        wr_slot(2, 2, 300, 16, 1, 0, 0);
        wr_slot(2, 3, 400, 16, 2, 0, 0);
        wr_slot(3, 0, 50, 16, 1, 2, 1);
        for (int p = 4; p < 16; p++) begin
            int ns;
            ns = 1 + $urandom % 4;
            for (int s = 0; s < ns; s++) begin
                int md;
                md = ($urandom % 8 == 0) ? 0 : 1 + $urandom % 3;
                wr_slot(p, s, $urandom % 32768, 16 + $urandom % 25, md,
                        $urandom % 5, s == ns - 1);
            end
        end
        check("R1 idle after writes", rd_valid, 0);

        // R3, R4, R6, R7, R8 on program 0
        tick(1, 0, 0, 0, "R3 start");
        check("R3 first address", rd_addr, 100);
        check("R2 stored base used", act_slot, 0);
        idle(16, "R4 wrap");
        check("R4 wrap to base", rd_addr, 100);
        idle(51, "R6 counted");
        check("R7 slot1 last word", rd_addr, 519);
        check("R6 advanced to slot1", act_slot, 1);
        tick(0, 0, 0, 0, "R8 end");
        check("R8 done set", done, 1);
        check("R8 valid low", rd_valid, 0);
        idle(5, "R8 hold");
        check("R8 done holds", done, 1);

        // R5 forever, then R10 deferred with replacement
        tick(1, 1, 0, 0, "R5 start");
        idle(200, "R5 forever");
        check("R5 still running", rd_valid, 1);
        check("R5 still slot0", act_slot, 0);
        tick(1, 3, 0, 0, "R10 defer a");
        check("R10 not yet switched", act_prog, 1);
        tick(1, 2, 0, 0, "R10 defer b");
        idle(16, "R10 boundary");
        check("R10 replaced request wins", act_prog, 2);

        // R4 address wrap across memory top, R7 mode 3, R6 zero count
        tick(1, 2, 1, 0, "R9 restart p2");
        check("R4 high base", rd_addr, 32760);
        idle(8, "R4 mem wrap");
        check("R4 modulo address", rd_addr, 0);
        idle(56, "R7 chain");
        check("R8 slot3 final", done, 1);

        // R9 immediate and discard of waiting deferred request
        tick(1, 1, 0, 0, "R9 start p1");
        idle(3, "R9 run");
        tick(1, 2, 0, 0, "R9 defer p2");
        tick(1, 3, 1, 0, "R9 imm p3");
        check("R9 immediate prog", act_prog, 3);
        check("R9 immediate addr", rd_addr, 50);
        idle(40, "R9 discard");
        check("R9 pending discarded", act_prog, 3);
        check("R9 p3 done", done, 1);

        // R11 pseudo-random source forces immediate
        tick(1, 1, 0, 0, "R11 start p1");
        idle(5, "R11 run");
        tick(1, 0, 0, 1, "R11 prbs req");
        check("R11 switched now", act_prog, 0);
        check("R11 address", rd_addr, 100);

        // mixed random traffic against the model (R4, R10, R11)
        for (int i = 0; i < 20000; i++) begin
            bit r, nw, pb;
            r  = ($urandom % 100) < 4;
            nw = ($urandom % 3) == 0;
            pb = ($urandom % 8) == 0;
            tick(r, $urandom % 16, nw, pb, "R10 random");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule